// File: doc/BRIEF.md
# Audio DMA Position and Sample Counter

This block keeps the position bookkeeping for one DMA audio channel. It holds a frame base address, a circular buffer position counted in 32-bit words, a byte remainder below one word, and a down-counter of samples that schedules interrupts. For every sample moved between memory and the converter, the data path pulses a strobe. The block advances the word position and the remainder by the byte size of one sample, which comes from the format code. From these it forms the byte address of the next transfer.

Software loads the frame register as a pair: buffer size in words minus one, and the current word index. It loads the sample register as a pair: reload value minus one, and the current remaining count. Both pairs read back as live values. In loop mode the word index wraps to zero once the last word of the buffer has been consumed. In single-shot mode the index parks on the last word and the channel drops its transfer request until the frame register is written again.

Top module: `audio_dma_counter`

## Requirements
- R1: After a synchronous active-low reset, frame_cnt, sample_cnt and xfer_addr read 0, irq is 0 and xfer_active is 1.
- R2: The format code sets the bytes per sample: 0 (8-bit mono) gives 1, 1 (8-bit stereo) gives 2, 2 (16-bit mono) gives 2, 3 (16-bit stereo) gives 4. Each accepted strobe adds that size to a 2-bit byte remainder. Every carry past 4 bytes advances the word index in frame_cnt[31:16] by one.
- R3: xfer_addr equals the base address, plus 4 times the word index, plus the byte remainder.
- R4: sample_cnt[31:16] is the remaining count and sample_cnt[15:0] the reload. An accepted strobe with a nonzero remaining count decrements it. With a remaining count of 0, the strobe loads the reload value into the remaining count instead.
- R5: A reloading strobe raises irq for exactly the following cycle when int_en is 1. When int_en is 0, irq stays 0.
- R6: With no_loop = 0, a word carry while the index equals the size field (frame_cnt[15:0]) sets the index to 0.
- R7: With no_loop = 1, that carry leaves the index unchanged, clears the remainder and drops xfer_active. While xfer_active is 0, strobes change neither counter. A frame write restores xfer_active to 1.
- R8: A frame write loads frame_cnt from frame_wdata and clears the remainder, taking priority over a strobe in the same cycle.
- R9: A sample write loads sample_cnt from sample_wdata, taking priority over a strobe in the same cycle. That strobe raises no irq.
- R10: A base write loads the base address used by xfer_addr from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Load the frame base address |
| base_wdata | input | 32 | New base address |
| frame_we | input | 1 | Load the frame register |
| frame_wdata | input | 32 | Index in [31:16], size minus one in [15:0] |
| sample_we | input | 1 | Load the sample register |
| sample_wdata | input | 32 | Remaining count in [31:16], reload in [15:0] |
| fmt | input | 2 | Sample format code |
| no_loop | input | 1 | 1 selects single-shot, 0 selects loop |
| int_en | input | 1 | Allows interrupt requests |
| sample_stb | input | 1 | One sample transferred |
| xfer_addr | output | 32 | Byte address of the next transfer |
| frame_cnt | output | 32 | Live frame register |
| sample_cnt | output | 32 | Live sample register |
| irq | output | 1 | One-cycle interrupt request |
| xfer_active | output | 1 | Channel still requests transfers |

## Verification
The hardest state to reach is a word carry that lands exactly on the last buffer word. At that moment the loop setting alone decides between wrapping to zero and parking. The bench reaches it directly by writing a frame value whose index already equals the size field, so a single 4-byte strobe crosses the end. It also reaches it indirectly by accumulating 2-byte strobes through a two-word buffer. A write issued together with a strobe, including a sample write that would otherwise trigger a reload interrupt, checks that the write takes priority.

// File: rtl/adma_pkg.sv
// Shared definitions for the audio DMA counter.
// Assumes the format code packs the stereo flag in bit 0 and the 16-bit flag in bit 1.
package adma_pkg;

    typedef enum logic [1:0] {
        FMT_U8_MONO    = 2'd0,
        FMT_U8_STEREO  = 2'd1,
        FMT_S16_MONO   = 2'd2,
        FMT_S16_STEREO = 2'd3
    } sample_fmt_e;

    // log2 of the bytes per sample: one step for stereo, one step for 16-bit
    function automatic logic [1:0] sample_shift(input sample_fmt_e f);
        return {1'b0, f[0]} + {1'b0, f[1]};
    endfunction

endpackage

// File: rtl/adma_sample_cnt.sv
// Sample down-counter with reload and interrupt pulse.
// Holds {remaining, reload} as two CW-bit halves. A write wins over a step in the same cycle.
// irq is registered: it is high in the cycle after the reloading step.
module adma_sample_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2*CW-1:0] wdata,
    input  logic          step,
    input  logic          int_en,
    output logic [2*CW-1:0] cnt,
    output logic          irq
);
    logic [CW-1:0] cur_q, rel_q;
    logic          irq_q;

    // Count down on each step, reload at zero, and pulse irq when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            rel_q <= '0;
            irq_q <= 1'b0;
        end else if (we) begin
            cur_q <= wdata[2*CW-1:CW];
            rel_q <= wdata[CW-1:0];
            irq_q <= 1'b0;
        end else if (step) begin
            if (cur_q == '0) begin
                cur_q <= rel_q;
                irq_q <= int_en;
            end else begin
                cur_q <= cur_q - 1'b1;
                irq_q <= 1'b0;
            end
        end else begin
            irq_q <= 1'b0;
        end
    end

    assign cnt = {cur_q, rel_q};
    assign irq = irq_q;
endmodule

// File: rtl/adma_frame_pos.sv
// Word position inside a circular buffer plus a byte remainder.
// Holds {index, size-1}. Each step adds (1 << shift) bytes to the remainder, and a carry
// advances the index. At the last word the index either wraps (loop) or parks and sets done.
// A write wins over a step and clears the remainder and done.
module adma_frame_pos #(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [2*CW-1:0] wdata,
    input  logic            step,
    input  logic [1:0]      shift,
    input  logic            no_loop,
    output logic [2*CW-1:0] cnt,
    output logic [1:0]      leftover,
    output logic            done
);
    logic [CW-1:0] idx_q, size_q;
    logic [1:0]    left_q;
    logic          done_q;
    logic [2:0]    total;
    logic          carry, at_end;

    // Byte sum of the remainder and one sample; bit 2 is the word carry
    always_comb begin
        total  = {1'b0, left_q} + (3'd1 << shift);
        carry  = total[2];
        at_end = (idx_q >= size_q);
    end

    // Advance, wrap or park the word index and keep the remainder modulo 4
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            size_q <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else if (we) begin
            idx_q  <= wdata[2*CW-1:CW];
            size_q <= wdata[CW-1:0];
            left_q <= '0;
            done_q <= 1'b0;
        end else if (step) begin
            left_q <= total[1:0];
            if (carry) begin
                if (!at_end) begin
                    idx_q <= idx_q + 1'b1;
                end else if (no_loop) begin
                    done_q <= 1'b1;
                    left_q <= '0;
                end else begin
                    idx_q <= '0;
                end
            end
        end
    end

    assign cnt      = {idx_q, size_q};
    assign leftover = left_q;
    assign done     = done_q;
endmodule

// File: rtl/audio_dma_counter.sv
// Per-channel DMA position engine: base address register, frame position and sample counter.
// Assumes at most one sample strobe per cycle and AW >= CW + 2.
// Strobes are ignored once a single-shot buffer has finished.
module audio_dma_counter #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_we,
    input  logic [AW-1:0]   base_wdata,
    input  logic            frame_we,
    input  logic [2*CW-1:0] frame_wdata,
    input  logic            sample_we,
    input  logic [2*CW-1:0] sample_wdata,
    input  logic [1:0]      fmt,
    input  logic            no_loop,
    input  logic            int_en,
    input  logic            sample_stb,
    output logic [AW-1:0]   xfer_addr,
    output logic [2*CW-1:0] frame_cnt,
    output logic [2*CW-1:0] sample_cnt,
    output logic            irq,
    output logic            xfer_active
);
    import adma_pkg::*;

    localparam int PAD = AW - CW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    left;
    logic          done;
    logic          step;
    logic [1:0]    shift;

    // Hold the frame base address
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    // Accept strobes only while the channel is active and derive the sample size
    always_comb begin
        step  = sample_stb && !done;
        shift = sample_shift(sample_fmt_e'(fmt));
    end

    adma_frame_pos #(.CW(CW)) i_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (frame_we),
        .wdata    (frame_wdata),
        .step     (step),
        .shift    (shift),
        .no_loop  (no_loop),
        .cnt      (frame_cnt),
        .leftover (left),
        .done     (done)
    );

    adma_sample_cnt #(.CW(CW)) i_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sample_we),
        .wdata  (sample_wdata),
        .step   (step),
        .int_en (int_en),
        .cnt    (sample_cnt),
        .irq    (irq)
    );

    // Byte address: base plus word index times four plus the remainder
    always_comb begin
        xfer_addr = base_q + {{PAD{1'b0}}, frame_cnt[2*CW-1:CW], 2'b00}
                           + {{(AW-2){1'b0}}, left};
    end

    assign xfer_active = !done;
endmodule

// File: rtl/audio_dma_counter_chk.sv
// Temporal checks on the ports of audio_dma_counter, attached with bind.
module audio_dma_counter_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_we,
    input logic [2*CW-1:0] frame_wdata,
    input logic            sample_we,
    input logic [2*CW-1:0] sample_wdata,
    input logic            int_en,
    input logic            sample_stb,
    input logic [2*CW-1:0] frame_cnt,
    input logic [2*CW-1:0] sample_cnt,
    input logic            irq,
    input logic            xfer_active
);
    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(int_en) && $past(sample_stb));

    // R7
    parked_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && !frame_we) |=> (!xfer_active && $stable(frame_cnt)));

    // R8
    frame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_we |=> (frame_cnt == $past(frame_wdata)) && xfer_active);

    // R9
    sample_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_we |=> (sample_cnt == $past(sample_wdata)) && !irq);

    // R2
    size_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_we |=> frame_cnt[CW-1:0] == $past(frame_cnt[CW-1:0]));
endmodule

bind audio_dma_counter audio_dma_counter_chk #(.AW(AW), .CW(CW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_we     (frame_we),
    .frame_wdata  (frame_wdata),
    .sample_we    (sample_we),
    .sample_wdata (sample_wdata),
    .int_en       (int_en),
    .sample_stb   (sample_stb),
    .frame_cnt    (frame_cnt),
    .sample_cnt   (sample_cnt),
    .irq          (irq),
    .xfer_active  (xfer_active)
);

// File: tb/test_audio_dma_counter.sv
module test_audio_dma_counter;
    localparam logic [31:0] BASE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        frame_we = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic        sample_we = 1'b0;
    logic [31:0] sample_wdata = '0;
    logic [1:0]  fmt = 2'd0;
    logic        no_loop = 1'b0;
    logic        int_en = 1'b0;
    logic        sample_stb = 1'b0;
    logic [31:0] xfer_addr, frame_cnt, sample_cnt;
    logic        irq, xfer_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    audio_dma_counter i_audio_dma_counter (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_wdata(base_wdata),
        .frame_we(frame_we), .frame_wdata(frame_wdata),
        .sample_we(sample_we), .sample_wdata(sample_wdata),
        .fmt(fmt), .no_loop(no_loop), .int_en(int_en), .sample_stb(sample_stb),
        .xfer_addr(xfer_addr), .frame_cnt(frame_cnt), .sample_cnt(sample_cnt),
        .irq(irq), .xfer_active(xfer_active)
    );

    typedef struct packed {
        logic [31:0] fw;
        logic [1:0]  f;
        logic        nl;
        logic [7:0]  n;
        logic [31:0] ef;
        logic [31:0] eo;
        logic        act;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{32'h0000_0007, 2'd0, 1'b0, 8'd5, 32'h0001_0007, 32'd5,  1'b1}, // R2 1 byte
        '{32'h0000_0007, 2'd1, 1'b0, 8'd3, 32'h0001_0007, 32'd6,  1'b1}, // R2 2 bytes
        '{32'h0002_0007, 2'd3, 1'b0, 8'd3, 32'h0005_0007, 32'd20, 1'b1}, // R2 4 bytes
        '{32'h0003_0003, 2'd3, 1'b0, 8'd1, 32'h0000_0003, 32'd0,  1'b1}, // R6 wrap
        '{32'h0003_0003, 2'd3, 1'b1, 8'd2, 32'h0003_0003, 32'd12, 1'b0}, // R7 park
        '{32'h0000_0001, 2'd2, 1'b0, 8'd5, 32'h0000_0001, 32'd2,  1'b1}  // R6 wrap via remainder
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic strobe(input int n);
        for (int k = 0; k < n; k++) begin
            sample_stb = 1'b1;
            tick();
        end
        sample_stb = 1'b0;
    endtask

    task automatic write_frame(input logic [31:0] v);
        frame_we = 1'b1; frame_wdata = v;
        tick();
        frame_we = 1'b0;
    endtask

    task automatic write_sample(input logic [31:0] v);
        sample_we = 1'b1; sample_wdata = v;
        tick();
        sample_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 frame", frame_cnt, 32'h0);
        check("R1 sample", sample_cnt, 32'h0);
        check("R1 addr", xfer_addr, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 active", {31'd0, xfer_active}, 32'd1);

        // R10 base address
        base_we = 1'b1; base_wdata = BASE;
        tick();
        base_we = 1'b0;
        check("R10 base", xfer_addr, BASE);

        write_sample(32'hFFFF_FFFF);
        for (int v = 0; v < 6; v++) begin
            fmt = VEC[v].f; no_loop = VEC[v].nl;
            write_frame(VEC[v].fw);
            strobe(int'(VEC[v].n));
            check("R2/R6/R7 frame", frame_cnt, VEC[v].ef);
            check("R3 addr", xfer_addr, BASE + VEC[v].eo);
            check("R7 active", {31'd0, xfer_active}, {31'd0, VEC[v].act});
        end

        // R7: park state from the previous vector, strobes ignored
        fmt = 2'd3; no_loop = 1'b1;
        write_frame(32'h0003_0003);
        strobe(1);
        check("R7 parked", {31'd0, xfer_active}, 32'd0);
        write_sample(32'h0005_0009);
        strobe(3);
        check("R7 frame held", frame_cnt, 32'h0003_0003);
        check("R7 addr held", xfer_addr, BASE + 32'd12);
        check("R7 sample held", sample_cnt, 32'h0005_0009);
        write_frame(32'h0000_0003);
        check("R7 restart", {31'd0, xfer_active}, 32'd1);
        no_loop = 1'b0;

        // R4 / R5 countdown and reload with interrupt
        fmt = 2'd0; int_en = 1'b1;
        write_sample(32'h0002_0002);
        strobe(1);
        check("R4 dec", sample_cnt, 32'h0001_0002);
        strobe(1);
        check("R4 zero", sample_cnt, 32'h0000_0002);
        check("R5 no irq yet", {31'd0, irq}, 32'd0);
        strobe(1);
        check("R4 reload", sample_cnt, 32'h0002_0002);
        check("R5 irq", {31'd0, irq}, 32'd1);
        tick();
        check("R5 one cycle", {31'd0, irq}, 32'd0);

        // R5 disabled interrupt
        int_en = 1'b0;
        write_sample(32'h0000_0006);
        strobe(1);
        check("R4 reload off", sample_cnt, 32'h0006_0006);
        check("R5 masked", {31'd0, irq}, 32'd0);

        // R8 frame write wins over strobe
        fmt = 2'd3;
        frame_we = 1'b1; frame_wdata = 32'h0002_0005; sample_stb = 1'b1;
        tick();
        frame_we = 1'b0; sample_stb = 1'b0;
        check("R8 frame", frame_cnt, 32'h0002_0005);
        check("R8 addr", xfer_addr, BASE + 32'd8);

        // R9 sample write wins over a reloading strobe
        int_en = 1'b1;
        write_sample(32'h0000_0003);
        sample_we = 1'b1; sample_wdata = 32'h0000_0004; sample_stb = 1'b1;
        tick();
        sample_we = 1'b0; sample_stb = 1'b0;
        check("R9 sample", sample_cnt, 32'h0000_0004);
        check("R9 no irq", {31'd0, irq}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule